// File: doc/BRIEF.md
# Three-Wire Register Interface

This block is the serial slave that configures an imaging front end. A host drives three lines: a frame-enable line, a serial clock and a bidirectional data line. Together they write and read a bank of five configuration registers: operating mode, variable gain, black clamp target, control flags and front-end gain. The block oversamples the three lines with the chip clock. It decodes each frame into a direction bit, a register address and a guard bit, then receives or returns the register contents least significant bit first.

A write frame can run on past the end of its first register. In that case the address advances and the next register is filled. Received values wait in shadow storage and become visible only when the frame-enable line goes high, so every register touched by a frame changes in the same cycle. Setting a reset flag in the mode register returns the whole bank to its reset values. A configurable lockout after power-on discards all writes. The block also presents the front-end gain code actually in effect, which depends on an enable flag in the control register.

Top module: `regIf3w`

## Requirements
- R1: A frame begins when `sLoad` falls. Bits are sampled on rising `sClk` edges in this order: direction bit (0 = write, 1 = read), address bits 0, 1, 2, a guard bit, then data starting at bit 0.
- R2: Address 0 holds an 11-bit mode word, 1 a 10-bit gain, 2 an 8-bit clamp level, 3 a 10-bit control word and 4 a 6-bit front-end gain. Addresses 5 to 7 hold no register: a write there changes nothing and a read there returns zeros over 11 bits.
- R3: In a write frame, once a register's last bit has arrived, the following bits fill the next address, with each register taking exactly its own length.
- R4: A register whose bits stop before its full length at the end of a frame keeps its committed value.
- R5: Register outputs change only when `sLoad` rises. At that point every fully received register of the frame updates together, and until then the outputs keep their old values.
- R6: In a read frame with the guard bit at 0, `sDataOe` goes high and `sDataOut` carries bit k of the addressed register after falling `sClk` edge number 5+k. A read changes no register.
- R7: After reset, mode = 0x000, gain = 0x096, clamp = 0x080, control = 0x000 and front-end gain = 0x00.
- R8: Committing a mode word with bit 4 set returns all five registers, the mode word included, to their reset values. This takes precedence over any other register written in the same frame.
- R9: For `LOCK_CYCLES` clock cycles after reset, completed writes are discarded. Writes made afterwards take effect.
- R10: `feGainEff` equals the front-end gain register when control bit 3 is 1, and equals 63 when that bit is 0.
- R11: A frame whose guard bit is 1 writes nothing and drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the serial lines |
| rstN | input | 1 | Active-low reset; starts the write lockout |
| sLoad | input | 1 | Frame enable: low during a frame, rising edge commits |
| sClk | input | 1 | Serial bit clock |
| sDataIn | input | 1 | Serial data from the host |
| sDataOut | output | 1 | Serial readback data |
| sDataOe | output | 1 | Drive enable for readback data |
| opWord | output | 11 | Committed mode word |
| gainCode | output | 10 | Committed variable gain code |
| clampLevel | output | 8 | Committed black clamp target |
| ctrlWord | output | 10 | Committed control word |
| feGainCode | output | 6 | Committed front-end gain register |
| feGainEff | output | 6 | Front-end gain code in effect |

## Verification
The bench targets four corner cases.

- Bursts whose registers have unequal lengths. A design that used a single fixed length would place every later register's bits at the wrong offsets.
- Frames cut short mid-register. A design that committed partial data would corrupt the last register.
- A reset flag committed in the same burst as other registers. A design with the wrong priority would leave the gain at the burst value rather than its default.
- Writes that finish inside the lockout window. A design that ignored the lockout would change the clamp level straight after reset.

Readback is sampled half a bit after each falling edge, so an output that ran one edge early or late shows up as a shifted word.

// File: rtl/regIfPkg.sv
package regIfPkg;
  localparam int NUM_REGS    = 5;
  localparam int MAX_LEN     = 11;
  localparam int HDR_BITS    = 5;
  localparam int ADDR_W      = 3;
  localparam int IDX_W       = $clog2(MAX_LEN + 1);
  localparam int BIT_CNT_W   = 7;
  localparam int FE_W        = 6;
  localparam int SOFT_RST_BIT = 4;
  localparam int GAIN_EN_BIT  = 3;
  localparam int FE_FIXED     = 63;

  typedef logic [MAX_LEN-1:0] word_t;

  typedef struct packed {
    logic                 frameStart;
    logic                 commit;
    logic                 wrEn;
    logic [ADDR_W-1:0]    wrAddr;
    word_t                wrData;
    logic                 rdShift;
    logic [ADDR_W-1:0]    rdAddr;
    logic [BIT_CNT_W-1:0] rdIdx;
  } strobe_t;

  function automatic int regLen(input logic [ADDR_W-1:0] a);
    case (a)
      3'd0: return 11;
      3'd1: return 10;
      3'd2: return 8;
      3'd3: return 10;
      3'd4: return 6;
      default: return MAX_LEN;
    endcase
  endfunction

  function automatic word_t regInit(input logic [ADDR_W-1:0] a);
    case (a)
      3'd1: return word_t'(11'h096);
      3'd2: return word_t'(11'h080);
      default: return '0;
    endcase
  endfunction

  function automatic word_t lenMask(input logic [ADDR_W-1:0] a);
    return word_t'((1 << regLen(a)) - 1);
  endfunction
endpackage

// File: rtl/regIfCtrl.sv
module regIfCtrl
  import regIfPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lockBusy,
  input  logic    sLoad,
  input  logic    sClk,
  input  logic    sDataIn,
  output strobe_t strb,
  output logic    sDataOe
);
  logic [SYNC_STAGES-1:0] loadQ, clkQ, dataQ;
  logic loadPrev, clkPrev;
  logic loadS, clkS, dataS;
  logic loadFall, loadRise, clkRise, clkFall;

  logic [BIT_CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0]     dataIdx;
  logic [ADDR_W-1:0]    curAddr;
  logic                 isRead, testBad;
  word_t                accum, bitWord;

  assign loadS    = loadQ[SYNC_STAGES-1];
  assign clkS     = clkQ[SYNC_STAGES-1];
  assign dataS    = dataQ[SYNC_STAGES-1];
  assign loadFall = loadPrev & ~loadS;
  assign loadRise = ~loadPrev & loadS;
  assign clkRise  = ~clkPrev & clkS & ~loadS;
  assign clkFall  = clkPrev & ~clkS & ~loadS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ    <= '1;
      clkQ     <= '0;
      dataQ    <= '0;
      loadPrev <= 1'b1;
      clkPrev  <= 1'b0;
    end else begin
      loadQ    <= {loadQ[SYNC_STAGES-2:0], sLoad};
      clkQ     <= {clkQ[SYNC_STAGES-2:0], sClk};
      dataQ    <= {dataQ[SYNC_STAGES-2:0], sDataIn};
      loadPrev <= loadS;
      clkPrev  <= clkS;
    end
  end

  always_comb begin
    bitWord = accum;
    bitWord[dataIdx] = dataS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb    <= '0;
      bitCnt  <= '0;
      dataIdx <= '0;
      curAddr <= '0;
      isRead  <= 1'b0;
      testBad <= 1'b0;
      accum   <= '0;
      sDataOe <= 1'b0;
    end else begin
      strb.frameStart <= loadFall;
      strb.commit     <= loadRise;
      strb.wrEn       <= 1'b0;
      strb.rdShift    <= 1'b0;
      if (loadFall || loadRise) sDataOe <= 1'b0;
      if (loadFall) begin
        bitCnt  <= '0;
        dataIdx <= '0;
        curAddr <= '0;
        isRead  <= 1'b0;
        testBad <= 1'b0;
        accum   <= '0;
      end else if (clkRise) begin
        if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
        case (bitCnt)
          BIT_CNT_W'(0): isRead     <= dataS;
          BIT_CNT_W'(1): curAddr[0] <= dataS;
          BIT_CNT_W'(2): curAddr[1] <= dataS;
          BIT_CNT_W'(3): curAddr[2] <= dataS;
          BIT_CNT_W'(4): testBad    <= dataS;
          default: if (!isRead) begin
            if (int'(dataIdx) == regLen(curAddr) - 1) begin
              strb.wrEn   <= !testBad && !lockBusy;
              strb.wrAddr <= curAddr;
              strb.wrData <= bitWord;
              curAddr     <= curAddr + 1'b1;
              dataIdx     <= '0;
              accum       <= '0;
            end else begin
              accum   <= bitWord;
              dataIdx <= dataIdx + 1'b1;
            end
          end
        endcase
      end else if (clkFall) begin
        if (isRead && !testBad && bitCnt >= BIT_CNT_W'(HDR_BITS)) begin
          strb.rdShift <= 1'b1;
          strb.rdAddr  <= curAddr;
          strb.rdIdx   <= bitCnt - BIT_CNT_W'(HDR_BITS);
          sDataOe      <= 1'b1;
        end
      end
    end
  end

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    sDataOe |-> isRead) else $error("drive enable outside a read frame"); // R6

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !isRead) else $error("write strobe in a read frame"); // R1
endmodule

// File: rtl/regIfBank.sv
module regIfBank
  import regIfPkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strb,
  output logic [NUM_REGS-1:0][MAX_LEN-1:0]   liveVec,
  output logic [FE_W-1:0]                    feGainEff,
  output logic                               sDataOut
);
  logic [NUM_REGS-1:0][MAX_LEN-1:0] shadowVec;
  logic [NUM_REGS-1:0][MAX_LEN-1:0] initVec;
  logic [NUM_REGS-1:0]              pendVec;
  logic                             softRst;
  logic                             rdBit;

  assign softRst = pendVec[0] && shadowVec[0][SOFT_RST_BIT];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gReg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);
    word_t shadowQ, liveQ;
    logic  pendQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ <= '0;
        pendQ   <= 1'b0;
        liveQ   <= regInit(MY_ADDR);
      end else begin
        if (strb.frameStart) pendQ <= 1'b0;
        else if (strb.wrEn && strb.wrAddr == MY_ADDR) begin
          shadowQ <= strb.wrData & lenMask(MY_ADDR);
          pendQ   <= 1'b1;
        end else if (strb.commit) pendQ <= 1'b0;
        if (strb.commit) begin
          if (softRst) liveQ <= regInit(MY_ADDR);
          else if (pendQ) liveQ <= shadowQ;
        end
      end
    end
    assign shadowVec[gi] = shadowQ;
    assign liveVec[gi]   = liveQ;
    assign pendVec[gi]   = pendQ;
    assign initVec[gi]   = regInit(MY_ADDR);
  end

  assign feGainEff = liveVec[3][GAIN_EN_BIT] ? liveVec[4][FE_W-1:0] : FE_W'(FE_FIXED);

  always_comb begin
    rdBit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (strb.rdAddr == ADDR_W'(i) && int'(strb.rdIdx) < regLen(ADDR_W'(i)))
        rdBit = liveVec[i][strb.rdIdx[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sDataOut <= 1'b0;
    else if (strb.frameStart) sDataOut <= 1'b0;
    else if (strb.rdShift) sDataOut <= rdBit;
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(liveVec)) else $error("register moved without commit"); // R5

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> pendVec == '0) else $error("pending flag survived commit"); // R5

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && softRst |=> liveVec == initVec) else $error("soft reset incomplete"); // R8
endmodule

// File: rtl/regIf3w.sv
module regIf3w
  import regIfPkg::*;
#(
  parameter int LOCK_CYCLES = 20000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sLoad,
  input  logic        sClk,
  input  logic        sDataIn,
  output logic        sDataOut,
  output logic        sDataOe,
  output logic [10:0] opWord,
  output logic [9:0]  gainCode,
  output logic [7:0]  clampLevel,
  output logic [9:0]  ctrlWord,
  output logic [5:0]  feGainCode,
  output logic [5:0]  feGainEff
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 2);

  logic [LOCK_W-1:0]                lockCnt;
  logic                             lockBusy;
  strobe_t                          ctrlStrb;
  logic [NUM_REGS-1:0][MAX_LEN-1:0] liveVec;
  logic                             unusedHi;

  assign lockBusy = lockCnt != LOCK_W'(LOCK_CYCLES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockCnt <= '0;
    else if (lockBusy) lockCnt <= lockCnt + 1'b1;
  end

  regIfCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .lockBusy(lockBusy),
    .sLoad(sLoad), .sClk(sClk), .sDataIn(sDataIn),
    .strb(ctrlStrb), .sDataOe(sDataOe)
  );

  regIfBank uBank (
    .clk(clk), .rstN(rstN), .strb(ctrlStrb),
    .liveVec(liveVec), .feGainEff(feGainEff), .sDataOut(sDataOut)
  );

  assign opWord     = liveVec[0][10:0];
  assign gainCode   = liveVec[1][9:0];
  assign clampLevel = liveVec[2][7:0];
  assign ctrlWord   = liveVec[3][9:0];
  assign feGainCode = liveVec[4][5:0];
  assign unusedHi   = ^{liveVec[1][10], liveVec[2][10:8], liveVec[3][10], liveVec[4][10:6]};

  AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    lockBusy |-> !ctrlStrb.wrEn) else $error("write during lockout"); // R9
endmodule

// File: tb/tb_regIf3w.sv
module tb_regIf3w;
  timeunit 1ns; timeprecision 1ps;
  localparam int LOCK = 500;
  localparam int HALF = 32;

  logic clk = 1'b0, rstN = 1'b0, sLoad = 1'b1, sClk = 1'b0, sDataIn = 1'b0;
  logic sDataOut, sDataOe;
  logic [10:0] opWord;
  logic [9:0]  gainCode, ctrlWord;
  logic [7:0]  clampLevel;
  logic [5:0]  feGainCode, feGainEff;

  always #2 clk = ~clk;

  regIf3w #(.LOCK_CYCLES(LOCK)) dut (
    .clk(clk), .rstN(rstN), .sLoad(sLoad), .sClk(sClk), .sDataIn(sDataIn),
    .sDataOut(sDataOut), .sDataOe(sDataOe), .opWord(opWord), .gainCode(gainCode),
    .clampLevel(clampLevel), .ctrlWord(ctrlWord), .feGainCode(feGainCode),
    .feGainEff(feGainEff)
  );

  int nChk = 0, nBad = 0;
  logic [10:0] model [0:4];
  logic [10:0] burstData [0:7];
  logic [63:0] frameBits;
  logic [10:0] rdBits;
  bit          oeAll;

  function automatic int lenOf(int a);
    case (a)
      0: return 11; 1: return 10; 2: return 8; 3: return 10; 4: return 6;
      default: return 11;
    endcase
  endfunction

  function automatic logic [10:0] initOf(int a);
    case (a)
      1: return 11'h096; 2: return 11'h080;
      default: return 11'h000;
    endcase
  endfunction

  function automatic logic [10:0] maskOf(int a);
    return 11'((1 << lenOf(a)) - 1);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(string req);
    chk(req, "mode", 32'(opWord), 32'(model[0]));
    chk(req, "gain", 32'(gainCode), 32'(model[1]));
    chk(req, "clamp", 32'(clampLevel), 32'(model[2]));
    chk(req, "control", 32'(ctrlWord), 32'(model[3]));
    chk(req, "feGain", 32'(feGainCode), 32'(model[4]));
    chk(req, "feGainEff", 32'(feGainEff), model[3][3] ? 32'(model[4][5:0]) : 32'd63);
  endtask

  task automatic shiftFrame(int n, int rdLen);
    sLoad = 1'b0;
    oeAll = 1'b1;
    for (int i = 0; i < n; i++) begin
      #HALF;
      if (i >= 5 && i - 5 < rdLen) begin
        rdBits[i-5] = sDataOut;
        if (sDataOe !== 1'b1) oeAll = 1'b0;
      end
      sDataIn = frameBits[i];
      #HALF; sClk = 1'b1;
      #HALF; sClk = 1'b0;
    end
    #HALF;
  endtask

  task automatic endFrame();
    sLoad = 1'b1;
    #(4*HALF);
  endtask

  task automatic writeBurst(int start, int cnt, int drop, bit test, bit locked);
    int pos;
    int a;
    int n;
    logic [4:0]  pend;
    logic [10:0] shadow [0:4];
    pos = 5;
    pend = '0;
    frameBits = '0;
    frameBits[1] = start[0];
    frameBits[2] = start[1];
    frameBits[3] = start[2];
    frameBits[4] = test;
    for (int j = 0; j < cnt; j++) begin
      a = (start + j) % 8;
      for (int b = 0; b < lenOf(a); b++) begin
        frameBits[pos] = burstData[j][b];
        pos++;
      end
    end
    n = pos - drop;
    pos = 5;
    for (int j = 0; j < cnt; j++) begin
      a = (start + j) % 8;
      pos += lenOf(a);
      if (a < 5 && pos <= n && !test && !locked) begin
        pend[a] = 1'b1;
        shadow[a] = burstData[j] & maskOf(a);
      end
    end
    shiftFrame(n, 0);
    checkOuts("R5");
    endFrame();
    if (pend[0] && shadow[0][4]) begin
      for (int k = 0; k < 5; k++) model[k] = initOf(k);
    end else begin
      for (int k = 0; k < 5; k++) if (pend[k]) model[k] = shadow[k];
    end
  endtask

  task automatic writeOne(int addr, logic [10:0] val);
    burstData[0] = val;
    writeBurst(addr, 1, 0, 1'b0, 1'b0);
  endtask

  task automatic readReg(int addr, string req);
    int L;
    logic [10:0] exp;
    L = lenOf(addr);
    frameBits = '0;
    frameBits[0] = 1'b1;
    frameBits[1] = addr[0];
    frameBits[2] = addr[1];
    frameBits[3] = addr[2];
    rdBits = '0;
    shiftFrame(5 + L, L);
    endFrame();
    exp = (addr < 5) ? model[addr] : 11'h000;
    chk(req, $sformatf("read addr %0d", addr), 32'(rdBits & maskOf(addr)), 32'(exp));
    chk(req, "read drive enable", 32'(oeAll), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    nChk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < 5; k++) model[k] = initOf(k);
    #40 rstN = 1'b1;
    #8;
    // R7 reset values
    checkOuts("R7");

    // R9 write finishing inside the lockout is dropped
    burstData[0] = 11'h033;
    writeBurst(2, 1, 0, 1'b0, 1'b1);
    checkOuts("R9");
    #2000;
    writeOne(2, 11'h0A5);
    checkOuts("R9");

    // R1 R2 single writes to every register, width clipping
    writeOne(0, 11'h0A3);
    writeOne(1, 11'h7FF);
    writeOne(3, 11'h208);
    writeOne(4, 11'h7D5);
    checkOuts("R1");
    writeOne(5, 11'h7FF);
    checkOuts("R2");

    // R10 effective gain follows enable bit
    writeOne(3, 11'h000);
    checkOuts("R10");
    chk("R10", "fixed code", 32'(feGainEff), 32'd63);
    writeOne(3, 11'h008);
    chk("R10", "register code", 32'(feGainEff), 32'h15);

    // R3 full burst over all registers
    burstData[0] = 11'h0C1; burstData[1] = 11'h2B3; burstData[2] = 11'h05A;
    burstData[3] = 11'h10F; burstData[4] = 11'h02E;
    writeBurst(0, 5, 0, 1'b0, 1'b0);
    checkOuts("R3");

    // R4 burst whose last register is cut short
    burstData[0] = 11'h0F0; burstData[1] = 11'h3C3; burstData[2] = 11'h011;
    writeBurst(2, 3, 3, 1'b0, 1'b0);
    checkOuts("R4");
    burstData[0] = 11'h155;
    writeBurst(1, 1, 1, 1'b0, 1'b0);
    checkOuts("R4");

    // R11 guard bit set
    burstData[0] = 11'h0EE;
    writeBurst(2, 1, 0, 1'b1, 1'b0);
    checkOuts("R11");

    // R6 readback of each register and of an empty address
    for (int a = 0; a < 6; a++) readReg(a, "R6");
    checkOuts("R6");

    // R8 soft reset wins over a gain written in the same burst
    burstData[0] = 11'h010; burstData[1] = 11'h155;
    writeBurst(0, 2, 0, 1'b0, 1'b0);
    checkOuts("R8");
    chk("R8", "mode bit cleared", 32'(opWord), 32'h0);

    // R3 R4 R5 constrained random bursts with readback
    for (int it = 0; it < 30; it++) begin
      int start;
      int cnt;
      int drop;
      start = int'($urandom % 5);
      cnt = 1 + int'($urandom % (5 - start));
      for (int j = 0; j < cnt; j++) begin
        burstData[j] = 11'($urandom);
        if (start + j == 0 && ($urandom % 8) != 0) burstData[j][4] = 1'b0;
      end
      drop = (($urandom % 4) == 0) ? 1 + int'($urandom % 5) : 0;
      writeBurst(start, cnt, drop, 1'b0, 1'b0);
      checkOuts("R3");
      readReg(int'($urandom % 5), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule